// File: doc/BRIEF.md
# Buried Register Diagnostic Readout Port

This block gives test logic a way to read the hidden registers of a sequencer core, one bit at a time. The core has sixteen state bits and two complement-array feedback bits. None of them reach a pin. The port watches a short entry handshake on the control levels. Once the port is armed, it decodes three select lines into one of eighteen register positions and drives that bit onto a single readout output.

Each control line is modelled as a 2-bit level code, so that the "extra-high" level used to enter test mode is an ordinary digital value. Every step of the handshake must be held for a minimum number of clock edges before the next step. While the port is active it asks the core to freeze its state registers, so that reading cannot disturb the machine.

Top module: `diag_readout_port`

## Requirements
- R1: After reset, `diag_active`, `core_freeze`, `readout` and `sel_err` are all 0.
- R2: Level codes are 2'b00 = low and 2'b01 = high. Both 2'b10 and 2'b11 mean extra-high.
- R3: With `oe_is_input` = 0, the port becomes active on the clock edge after these steps: `oe_pin` is held high for at least HOLD_CYC edges, and then `lvl_q0` is raised to extra-high while `oe_pin` stays high.
- R4: The port stays inactive in two cases: `lvl_q0` reaches extra-high before `oe_pin` has been high for HOLD_CYC edges, or `lvl_q0` is extra-high while `oe_pin` is still low.
- R5: With `oe_is_input` = 1, `lvl_in5` must be at extra-high for at least HOLD_CYC edges while `oe_pin` is low, before `oe_pin` rises. If `oe_pin` is raised without that step, the port is not entered.
- R6: The select index is 9·hi + 3·mid + lo, where each line counts low = 0, high = 1 and extra-high = 2. Index 0 selects C1 (`carry_bits[1]`), 1 selects state bit 15, 2 selects C0 (`carry_bits[0]`), and 3 selects state bit 14. Indices 4 to 17 select state bits 0 to 13 in ascending order.
- R7: While the port is active and the select is valid, `readout` equals the selected bit, combinationally. While the port is inactive, `readout` is 0.
- R8: An extra-high level on `sel_hi` is an invalid select. While the port is active, such a select forces `readout` to 0 and sets `sel_err` to 1. `sel_err` is 0 whenever the port is inactive.
- R9: `core_freeze` is 1 exactly while `diag_active` is 1.
- R10: While the port is active, if `lvl_q0` leaves extra-high or `oe_pin` goes low, the port is inactive after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oe_is_input | input | 1 | The output-enable pin also feeds the array (needs the input-5 pre-step) |
| oe_pin | input | 1 | Output-enable control, high = outputs disabled |
| lvl_in5 | input | 2 | Level code of input 5 |
| lvl_q0 | input | 2 | Level code of the mode-enable line |
| sel_hi | input | 2 | Level code of the first select line |
| sel_mid | input | 2 | Level code of the second select line |
| sel_lo | input | 2 | Level code of the third select line |
| state_bits | input | 16 | Buried state register bits of the core |
| carry_bits | input | 2 | Complement-array bits, [0] = C0, [1] = C1 |
| diag_active | output | 1 | Diagnostic mode is active |
| core_freeze | output | 1 | Request to hold the core's state registers |
| readout | output | 1 | Selected register bit |
| sel_err | output | 1 | Invalid select while active |

## Verification
Exit and the invalid-select error can fall in the same cycle. To provoke this, the bench drops `lvl_q0` at the moment it drives `sel_hi` to extra-high. It judges the result in two steps. Before the edge, `sel_err` is 1 and `readout` is 0. After the edge, the port is idle, with `sel_err`, `readout` and `core_freeze` all 0. A live select change and a change of the watched state bits are also made to coincide with active reads. The bench checks that the readout follows the new value within the same cycle.

// File: rtl/diag_readout_port.sv
module diag_readout_port #(
  parameter int HOLD_CYC = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        oe_is_input,
  input  logic        oe_pin,
  input  logic [1:0]  lvl_in5,
  input  logic [1:0]  lvl_q0,
  input  logic [1:0]  sel_hi,
  input  logic [1:0]  sel_mid,
  input  logic [1:0]  sel_lo,
  input  logic [15:0] state_bits,
  input  logic [1:0]  carry_bits,
  output logic        diag_active,
  output logic        core_freeze,
  output logic        readout,
  output logic        sel_err
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD = CW'(HOLD_CYC);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_OE, S_ACT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          q0_xh, in5_xh, held;

  assign q0_xh  = lvl_q0[1];
  assign in5_xh = lvl_in5[1];
  assign held   = (cnt >= HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= CW'(1);
          if (oe_is_input) begin
            if (in5_xh && !oe_pin && !q0_xh) st <= S_PRE;
          end else if (oe_pin && !q0_xh) begin
            st <= S_OE;
          end
        end
        S_PRE: begin
          if (!in5_xh || q0_xh) begin
            st <= S_IDLE;
          end else if (oe_pin) begin
            st  <= held ? S_OE : S_IDLE;
            cnt <= CW'(1);
          end else if (!held) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_OE: begin
          if (!oe_pin) begin
            st <= S_IDLE;
          end else if (q0_xh) begin
            st <= held ? S_ACT : S_IDLE;
          end else if (!held) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (!q0_xh || !oe_pin) st <= S_IDLE;
        end
      endcase
    end
  end

  function automatic logic [4:0] tern(input logic [1:0] l);
    return l[1] ? 5'd2 : (l[0] ? 5'd1 : 5'd0);
  endfunction

  logic [4:0] idx;
  logic       bad_sel, pick;

  assign idx     = 5'd9 * tern(sel_hi) + 5'd3 * tern(sel_mid) + tern(sel_lo);
  assign bad_sel = sel_hi[1];

  always_comb begin
    case (idx)
      5'd0:    pick = carry_bits[1];
      5'd1:    pick = state_bits[15];
      5'd2:    pick = carry_bits[0];
      5'd3:    pick = state_bits[14];
      default: pick = (idx <= 5'd17) ? state_bits[4'(idx - 5'd4)] : 1'b0;
    endcase
  end

  assign diag_active = (st == S_ACT);
  assign core_freeze = diag_active;
  assign sel_err     = diag_active & bad_sel;
  assign readout     = diag_active & ~bad_sel & pick;
endmodule

module diag_readout_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       oe_pin,
  input logic [1:0] lvl_q0,
  input logic       diag_active,
  input logic       core_freeze,
  input logic       readout,
  input logic       sel_err
);
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_active |-> !readout);
  a_r8_err_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> !readout);
  a_r8_err_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> diag_active);
  a_r9_read_while_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    readout |-> core_freeze);
  a_r3_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(diag_active) |-> ($past(lvl_q0[1]) && $past(oe_pin)));
  a_r10_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_active && (!lvl_q0[1] || !oe_pin)) |=> !diag_active);
endmodule

bind diag_readout_port diag_readout_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oe_pin(oe_pin), .lvl_q0(lvl_q0),
  .diag_active(diag_active), .core_freeze(core_freeze),
  .readout(readout), .sel_err(sel_err)
);

// File: tb/diag_readout_port_test.sv
module diag_readout_port_test;
  localparam int HOLD = 20;
  localparam logic [1:0] LO = 2'b00, HI = 2'b01, XH = 2'b10, XH2 = 2'b11;

  logic clk = 0, rst_n = 0, oe_is_input = 0, oe_pin = 0;
  logic [1:0] lvl_in5 = LO, lvl_q0 = LO, sel_hi = LO, sel_mid = LO, sel_lo = LO;
  logic [15:0] state_bits = 16'hA5C3;
  logic [1:0] carry_bits = 2'b10;
  logic diag_active, core_freeze, readout, sel_err;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  diag_readout_port #(.HOLD_CYC(HOLD)) uut (.*);

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic ref_bit(input int i, input logic [15:0] s, input logic [1:0] c);
    case (i)
      0: return c[1];
      1: return s[15];
      2: return c[0];
      3: return s[14];
      default: return s[i-4];
    endcase
  endfunction

  function automatic logic [1:0] code(input int t);
    return (t == 0) ? LO : (t == 1) ? HI : XH;
  endfunction

  task automatic go_idle();
    lvl_q0 = LO; oe_pin = 0; lvl_in5 = LO; sel_hi = LO; sel_mid = LO; sel_lo = LO;
    step(2);
  endtask

  task automatic enter(input logic [1:0] xh_code);
    if (oe_is_input) begin lvl_in5 = xh_code; step(HOLD); end
    oe_pin = 1; step(HOLD);
    lvl_q0 = xh_code; step(1);
  endtask

  task automatic t_reset();
    rst_n = 0; step(3);
    chk("R1 active", diag_active, 0);
    chk("R1 freeze", core_freeze, 0);
    chk("R1 readout", readout, 0);
    chk("R1 err", sel_err, 0);
    rst_n = 1; step(1);
  endtask

  task automatic t_entry_basic();
    oe_is_input = 0;
    oe_pin = 1; step(HOLD);
    chk("R3 not yet active", diag_active, 0);
    lvl_q0 = XH;
    @(posedge clk); #1;
    chk("R3 active after edge", diag_active, 1);
    chk("R9 freeze follows", core_freeze, 1);
    go_idle();
    enter(XH2);
    chk("R2 code 11 is extra-high", diag_active, 1);
    go_idle();
    chk("R9 freeze low idle", core_freeze, 0);
  endtask

  task automatic t_early_and_order();
    oe_pin = 1; step(HOLD - 1);
    lvl_q0 = XH; step(3);
    chk("R4 early q0", diag_active, 0);
    go_idle();
    lvl_q0 = XH; step(2);
    oe_pin = 1; step(HOLD + 2);
    chk("R4 q0 before oe", diag_active, 0);
    go_idle();
    lvl_q0 = HI; oe_pin = 1; step(HOLD + 2);
    chk("R2 high is not extra-high", diag_active, 0);
    go_idle();
  endtask

  task automatic t_oe_input();
    oe_is_input = 1;
    oe_pin = 1; step(HOLD); lvl_q0 = XH; step(2);
    chk("R5 no in5 step", diag_active, 0);
    go_idle();
    lvl_in5 = XH; step(HOLD - 1); oe_pin = 1; step(HOLD); lvl_q0 = XH; step(2);
    chk("R5 in5 too short", diag_active, 0);
    go_idle();
    enter(XH);
    chk("R5 full sequence", diag_active, 1);
    go_idle();
    oe_is_input = 0;
  endtask

  task automatic t_sweep(input logic [15:0] s, input logic [1:0] c);
    state_bits = s; carry_bits = c;
    enter(XH);
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 3; b++)
        for (int d = 0; d < 3; d++) begin
          sel_hi = code(a); sel_mid = code(b); sel_lo = code(d);
          step(1);
          chk($sformatf("R6 R7 index %0d", 9*a+3*b+d), readout, ref_bit(9*a+3*b+d, s, c));
        end
    sel_hi = LO; sel_mid = HI; sel_lo = HI;
    state_bits = s ^ 16'h0001; step(1);
    chk("R7 live data change", readout, ~s[0]);
    go_idle();
    chk("R7 idle readout", readout, 0);
  endtask

  task automatic t_invalid_and_exit();
    state_bits = 16'hFFFF; carry_bits = 2'b11;
    enter(XH);
    sel_hi = XH; sel_mid = LO; sel_lo = LO; step(1);
    chk("R8 err set", sel_err, 1);
    chk("R8 readout zero", readout, 0);
    sel_hi = LO; step(1);
    chk("R8 err clears", sel_err, 0);
    chk("R7 valid again", readout, 1);
    sel_hi = XH; lvl_q0 = HI;
    #1;
    chk("R8 err in exit cycle", sel_err, 1);
    @(posedge clk); #1;
    chk("R10 exit on q0 drop", diag_active, 0);
    chk("R8 err gone after exit", sel_err, 0);
    chk("R9 freeze released", core_freeze, 0);
    go_idle();
    enter(XH);
    oe_pin = 0;
    @(posedge clk); #1;
    chk("R10 exit on oe low", diag_active, 0);
    go_idle();
  endtask

  initial begin
    t_reset();
    t_entry_basic();
    t_early_and_order();
    t_oe_input();
    t_sweep(16'hA5C3, 2'b10);
    t_sweep(16'h5A3C, 2'b01);
    t_invalid_and_exit();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule